// File: doc/BRIEF.md
# Single-Register Interrupt Aggregator

This block gathers a small group of edge-type event inputs and drives one level-type interrupt line to a parent controller. Software sees and controls the whole block through a single 32-bit word. The low half-word holds one enable bit per source. The high half-word holds one latched status bit per source. Software clears a status bit by writing 1 to it.

The sources occupy a contiguous window of bit positions inside each half. Two parameters set the window: a start offset and a source count. Typical configurations are seven sources from bit 0, six sources from bit 0, and two sources starting at bit 4. Every bit outside the window is inert. Each source input is synchronized to the block clock. A rising edge on the synchronized input latches the status bit whether or not the source is enabled, so enabling the source later still shows the event.

The parent line is a registered OR, across the window, of status ANDed with enable. It stays high as long as any enabled status bit is set, which suits a level-triggered parent.

Top module: `irq_aggregator`

## Requirements
- R1: Bits 15:0 of the register word are the enable field. Bits 31:16 are the status field. The status bit paired with enable bit n sits at bit n+16.
- R2: Source input k (bit k of `src_in`) maps to enable bit SRC_BASE+k and to status bit SRC_BASE+k+16.
- R3: Enable and status bits outside the window always read 0. Writes to them have no effect, and they never influence `irq_out`.
- R4: A rising edge on a source input sets its status bit. Counting the clock edge that first samples the new level as edge 1, the status bit reads back as set after edge 3. A source held high does not set its bit again once the bit has been cleared.
- R5: A write with a 1 in a status bit position clears that status bit.
- R6: A write with a 0 in a status bit position leaves that status bit unchanged. Each write loads the enable field from the written word.
- R7: When a source edge and a write-one-to-clear reach the same status bit in the same cycle, the bit ends up set.
- R8: `irq_out` equals, one cycle later, the OR across the window of (status AND enable). It falls exactly one cycle after the last enabled pending bit is cleared or masked.
- R9: A status bit whose enable is 0 does not raise `irq_out`. Enabling that source later raises `irq_out` while the status bit is still held.
- R10: After reset, every enable and status bit is 0 and `irq_out` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Full-word write strobe for the register |
| bus_wdata | input | 32 | Write data: enables in 15:0, clear-on-one status in 31:16 |
| bus_rdata | output | 32 | Current register contents |
| src_in | input | SRC_COUNT | Asynchronous event inputs, one per source |
| irq_out | output | 1 | Aggregated level interrupt to the parent |

## Verification
Several properties are checked on every cycle: the window confinement of the read word, the write-one-to-clear and write-zero-keep rules for status, the rule that a set beats a clear, the one-cycle relation between the registered parent line and the register contents, and the reset state. Some behaviour can only be shown by the bench's scenarios. These are the synchronizer latency from an input edge to a visible status bit, the absence of re-triggering while a source is held high, a pending event revealed by enabling it later, and the exact cycle alignment that makes a clear collide with a new edge.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

    localparam int WORD_W = 32;
    localparam int HALF_W = 16;

    typedef logic [HALF_W-1:0] half_t;

    // Register word: status field above, enable field below
    typedef struct packed {
        half_t status;
        half_t enable;
    } ctl_word_t;

    // Ones over bits [base +: count] of a half-word
    function automatic half_t win_mask(input int base, input int count);
        half_t m;
        m = '0;
        for (int i = 0; i < HALF_W; i++) begin
            if (i >= base && i < base + count) m[i] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/irq_src_sync.sv
module irq_src_sync
    import irq_agg_pkg::*;
#(
    parameter int COUNT  = 7,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [COUNT-1:0] src_in,
    output logic [COUNT-1:0] rise_o
);

    localparam int LAST = STAGES - 1;

    for (genvar g = 0; g < COUNT; g++) begin : g_src
        logic [STAGES-1:0] sync_q;
        logic              prev_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                sync_q <= '0;
                prev_q <= 1'b0;
            end else begin
                sync_q <= {sync_q[STAGES-2:0], src_in[g]};
                prev_q <= sync_q[LAST];
            end
        end

        assign rise_o[g] = sync_q[LAST] & ~prev_q;
    end

endmodule

// File: rtl/irq_ctl_reg.sv
module irq_ctl_reg
    import irq_agg_pkg::*;
#(
    parameter int BASE  = 0,
    parameter int COUNT = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  ctl_word_t        wr_word,
    input  logic [COUNT-1:0] rise_in,
    output half_t            rise_pos,
    output ctl_word_t        ctl_q
);

    localparam half_t WIN = win_mask(BASE, COUNT);

    half_t     clr_bits;
    ctl_word_t ctl_d;

    assign rise_pos = half_t'(rise_in) << BASE;

    always_comb begin
        clr_bits     = wr_en ? wr_word.status : '0;
        ctl_d.enable = wr_en ? (wr_word.enable & WIN) : ctl_q.enable;
        // a new edge takes precedence over a same-cycle clear
        ctl_d.status = ((ctl_q.status & ~clr_bits) | rise_pos) & WIN;
    end

    always_ff @(posedge clk) begin
        if (rst) ctl_q <= '0;
        else     ctl_q <= ctl_d;
    end

endmodule

// File: rtl/irq_parent_out.sv
module irq_parent_out
    import irq_agg_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  ctl_word_t ctl,
    output logic      irq_o
);

    logic pend;

    assign pend = |(ctl.status & ctl.enable);

    always_ff @(posedge clk) begin
        if (rst) irq_o <= 1'b0;
        else     irq_o <= pend;
    end

endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
    import irq_agg_pkg::*;
#(
    parameter int SRC_BASE    = 0,
    parameter int SRC_COUNT   = 7,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_wr,
    input  logic [WORD_W-1:0]    bus_wdata,
    output logic [WORD_W-1:0]    bus_rdata,
    input  logic [SRC_COUNT-1:0] src_in,
    output logic                 irq_out
);

    logic [SRC_COUNT-1:0] rise_raw;
    half_t                rise_bits;
    ctl_word_t            wr_word;
    ctl_word_t            ctl_q;

    assign wr_word   = ctl_word_t'(bus_wdata);
    assign bus_rdata = WORD_W'(ctl_q);

    irq_src_sync #(
        .COUNT  (SRC_COUNT),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk    (clk),
        .rst    (rst),
        .src_in (src_in),
        .rise_o (rise_raw)
    );

    irq_ctl_reg #(
        .BASE  (SRC_BASE),
        .COUNT (SRC_COUNT)
    ) u_reg (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (bus_wr),
        .wr_word  (wr_word),
        .rise_in  (rise_raw),
        .rise_pos (rise_bits),
        .ctl_q    (ctl_q)
    );

    irq_parent_out u_out (
        .clk   (clk),
        .rst   (rst),
        .ctl   (ctl_q),
        .irq_o (irq_out)
    );

endmodule

// File: rtl/irq_aggregator_chk.sv
module irq_aggregator_chk
    import irq_agg_pkg::*;
#(
    parameter int SRC_BASE  = 0,
    parameter int SRC_COUNT = 7
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_wr,
    input logic [WORD_W-1:0] bus_wdata,
    input logic [WORD_W-1:0] bus_rdata,
    input logic              irq_out,
    input half_t             rise_bits
);

    localparam half_t WIN = win_mask(SRC_BASE, SRC_COUNT);

    half_t stat_v;
    half_t en_v;
    assign stat_v = bus_rdata[31:16];
    assign en_v   = bus_rdata[15:0];

    // R3: nothing outside the window is ever visible
    a_r3_window_only: assert property (@(posedge clk) disable iff (rst)
        ((stat_v & ~WIN) == '0) && ((en_v & ~WIN) == '0));

    // R5: a written 1 clears unless an edge arrives at the same bit
    a_r5_w1c: assert property (@(posedge clk) disable iff (rst)
        bus_wr |=> ((stat_v & $past(bus_wdata[31:16] & ~rise_bits)) == '0));

    // R6: status bits not written with 1 stay set
    a_r6_keep_status: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((stat_v & $past(stat_v & ~(bus_wr ? bus_wdata[31:16] : 16'h0)))
                  == $past(stat_v & ~(bus_wr ? bus_wdata[31:16] : 16'h0))));

    // R6: a write loads the in-window enable bits
    a_r6_enable_load: assert property (@(posedge clk) disable iff (rst)
        bus_wr |=> (en_v == $past(bus_wdata[15:0] & WIN)));

    // R7: an edge always leaves its status bit set
    a_r7_set_wins: assert property (@(posedge clk) disable iff (rst)
        (|rise_bits) |=> ((stat_v & $past(rise_bits)) == $past(rise_bits)));

    // R8: parent line follows enabled pending bits by one cycle
    a_r8_irq_follow: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (irq_out == $past(|(stat_v & en_v))));

    // R10: reset clears everything
    a_r10_reset: assert property (@(posedge clk)
        rst |=> ((bus_rdata == '0) && !irq_out));

endmodule

bind irq_aggregator irq_aggregator_chk #(
    .SRC_BASE  (SRC_BASE),
    .SRC_COUNT (SRC_COUNT)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_out   (irq_out),
    .rise_bits (rise_bits)
);

// File: tb/irq_aggregator_bench.sv
module irq_aggregator_bench;

    localparam int BASE  = 3;
    localparam int COUNT = 6;   // window is bits 8:3 of each half

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              bus_wr = 1'b0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [COUNT-1:0]  src_in = '0;
    logic              irq_out;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    irq_aggregator #(
        .SRC_BASE    (BASE),
        .SRC_COUNT   (COUNT),
        .SYNC_STAGES (2)
    ) u_irq_aggregator (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .src_in    (src_in),
        .irq_out   (irq_out)
    );

    // {write word, expected readback}; no status is pending during these rows
    localparam logic [63:0] VEC [0:5] = '{
        {32'hFFFF_FFFF, 32'h0000_01F8},
        {32'h0000_0007, 32'h0000_0000},
        {32'h0000_0108, 32'h0000_0108},
        {32'h0000_FE07, 32'h0000_0000},
        {32'h0000_00F0, 32'h0000_00F0},
        {32'h0000_0000, 32'h0000_0000}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] w);
        @(negedge clk);
        bus_wr    = 1'b1;
        bus_wdata = w;
        @(negedge clk);
        bus_wr    = 1'b0;
        bus_wdata = '0;
    endtask

    task automatic pulse(input logic [COUNT-1:0] pat);
        @(negedge clk);
        src_in = pat;
        repeat (3) @(negedge clk);
        src_in = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R10 reset word", bus_rdata, 32'h0);
        chk("R10 reset irq", 32'(irq_out), 32'h0);

        // R3 R6 R1: enable writes confined to the window
        for (int i = 0; i < 6; i++) begin
            wr(VEC[i][63:32]);
            chk("R3 window readback", bus_rdata, VEC[i][31:0]);
            chk("R3 no irq", 32'(irq_out), 32'h0);
        end

        // R4 R2 R9: disabled source latches, irq stays low
        pulse(6'b000001);
        chk("R4 edge latches bit 19", bus_rdata, 32'h0008_0000);
        @(negedge clk);
        chk("R9 disabled pending no irq", 32'(irq_out), 32'h0);
        wr(32'h0000_0008);
        chk("R6 enable write keeps status", bus_rdata, 32'h0008_0008);
        @(negedge clk);
        chk("R9 late enable reveals", 32'(irq_out), 32'h1);

        // R5 R8: clear and one-cycle deassert
        wr(32'h0008_0008);
        chk("R5 w1c", bus_rdata, 32'h0000_0008);
        chk("R8 irq still high", 32'(irq_out), 32'h1);
        @(negedge clk);
        chk("R8 irq falls one cycle later", 32'(irq_out), 32'h0);

        // R4: held-high source sets once only
        src_in = 6'b000001;
        repeat (3) @(negedge clk);
        chk("R4 held source sets", bus_rdata, 32'h0008_0008);
        wr(32'h0008_0008);
        repeat (4) @(negedge clk);
        chk("R4 no retrigger while held", bus_rdata, 32'h0000_0008);
        src_in = '0;
        repeat (3) @(negedge clk);

        // R7: clear collides with a new edge on bit 24
        src_in = 6'b100000;
        repeat (2) @(negedge clk);
        bus_wr    = 1'b1;
        bus_wdata = 32'h0100_0008;
        @(negedge clk);
        bus_wr    = 1'b0;
        bus_wdata = '0;
        src_in    = '0;
        chk("R7 set wins", bus_rdata, 32'h0100_0008);
        wr(32'h0100_0000);
        chk("R5 clear after collision", bus_rdata, 32'h0);
        repeat (3) @(negedge clk);

        // R2 R8 R9: several sources, then masking
        pulse(6'b101010);
        chk("R2 multi map", bus_rdata, 32'h0150_0000);
        wr(32'h0000_0150);
        @(negedge clk);
        chk("R8 irq on", 32'(irq_out), 32'h1);
        wr(32'h0000_0000);
        chk("R9 mask keeps status", bus_rdata, 32'h0150_0000);
        chk("R8 irq before fall", 32'(irq_out), 32'h1);
        @(negedge clk);
        chk("R8 mask drops irq", 32'(irq_out), 32'h0);
        wr(32'h0140_0000);
        chk("R5 partial clear", bus_rdata, 32'h0010_0000);

        // R3: status clear outside the window is inert
        wr(32'hFE07_01F8);
        chk("R3 outside clear inert", bus_rdata, 32'h0010_01F8);
        wr(32'h0000_0000);

        // R10: reset mid-run
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        chk("R10 reset clears word", bus_rdata, 32'h0);
        chk("R10 reset clears irq", 32'(irq_out), 32'h0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule